// File: doc/BRIEF.md
# Prioritized Interrupt Request Controller

This block gathers the hardware interrupt sources of a small 8-bit processor core and decides, at each instruction boundary, whether the core enters an interrupt and which vector it uses. The sources are two asynchronous external pins, a pulse from an internal timer and the software-interrupt instruction. Each external pin passes through a synchronizer. A falling edge of the synchronized level latches a sticky request. A running instruction is never cut short. Requests wait until the core reports that its current instruction is done.

At that boundary the controller picks the winner by fixed priority. The software interrupt is taken whatever the global disable flag says. Hardware sources are taken only when that flag is clear. On a win the controller pulses an entry strobe with a 2-bit vector select. Otherwise it pulses a fetch-proceed strobe. The timer and the second pin share one vector. Software identifies the source from their request flags in two CPU-visible 8-bit registers. Software can clear those flags but can never set them. The first pin's request clears itself when the core acknowledges an entry taken on its vector.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, no request is pending and both masks are 0. The irqEntry, fetchGo and vecSel outputs are 0. Register 0 reads 0x00, and register 1 reads 0x01 while pin B is high.
- R2: Two clock edges after extPinB falls, bit 0 of register 1 reads 0. Its request flag (register 1, bit 7) reads 1 after the third edge. A rising edge sets no request. Pin A is synchronized and edge-detected in the same way.
- R3: While instrDone is low, irqEntry and fetchGo stay 0 one cycle later, and pending requests are kept.
- R4: A cycle with instrDone high is followed by exactly one of two one-cycle pulses. irqEntry is pulsed, with vecSel valid, when an interrupt is taken. Otherwise fetchGo is pulsed. Vector codes are 00 for the software interrupt, 01 for pin A, and 10 for the timer or pin B.
- R5: While iFlag is high, no hardware request is taken at a boundary. The request stays latched and is taken at a later boundary with iFlag low.
- R6: A pin B request that arrives while its mask (register 1, bit 6) is 1 is still latched. It is not taken until the mask is written to 0. The timer mask (register 0, bit 6) acts the same way on the timer request (register 0, bit 7).
- R7: Priority at a boundary runs from highest to lowest: the software interrupt (swiReq with instrDone), then pin A, then the shared timer and pin B vector.
- R8: Writing 0 to bit 7 of either register clears that request. Writing 1 there has no effect. A request that arrives in the same cycle as a clearing write stays set.
- R9: An entryAck pulse while vecSel is 01 clears the pin A request. An acknowledge never clears the timer or pin B flags.
- R10: Bit 0 of register 1 always reads the synchronized level of pin B, whatever its mask.
- R11: The software interrupt is taken (irqEntry with vector 00) even when iFlag is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| extPinA | input | 1 | Asynchronous external interrupt pin A |
| extPinB | input | 1 | Asynchronous external interrupt pin B (shared vector) |
| timerReq | input | 1 | One-cycle request pulse from the timer |
| swiReq | input | 1 | The completing instruction is a software interrupt |
| instrDone | input | 1 | The current instruction completes this cycle |
| iFlag | input | 1 | Global interrupt-disable flag from the condition codes |
| entryAck | input | 1 | The core acknowledges the interrupt entry |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 1 | Register select: 0 = timer status, 1 = miscellaneous |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data of the selected register |
| irqEntry | output | 1 | Pulse: take an interrupt at this boundary |
| fetchGo | output | 1 | Pulse: proceed with the next instruction fetch |
| vecSel | output | 2 | Vector select of the last entry |

## Verification
Two things can meet in one cycle, and the bench drives both. The first is arbitration: several requests are pending at the same boundary. The bench sweeps every combination of pin A, timer and pin B requests, the two masks, iFlag and swiReq. For each it computes the expected winner arithmetically. It then checks, at a second boundary after the acknowledge, that only the pin A request was consumed. The second is a request arriving in the same cycle as a software write that clears it. The bench drives the timer pulse together with that write and expects the flag to remain set.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int REG_W     = 8;
  localparam int FLAG_BIT  = 7;
  localparam int MASK_BIT  = 6;
  localparam int LEVEL_BIT = 0;
  localparam int NUM_PINS  = 2;

  typedef enum logic [1:0] {
    VEC_SWI    = 2'b00,
    VEC_EXTA   = 2'b01,
    VEC_SHARED = 2'b10
  } vec_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clrExtA;
  } ctrl_strobe_t;

  // unmasked pending state from datapath to control
  typedef struct packed {
    logic extA;
    logic shared;
  } pend_t;
endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic pinIn,
  output logic level,
  output logic fallPulse
);
  logic [STAGES-1:0] chain;
  logic              prevLevel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chain     <= '1;
      prevLevel <= 1'b1;
    end else begin
      chain     <= {chain[STAGES-2:0], pinIn};
      prevLevel <= chain[STAGES-1];
    end
  end

  assign level     = chain[STAGES-1];
  assign fallPulse = prevLevel & ~level;

  // R2: an edge yields a single-cycle pulse
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    fallPulse |=> !fallPulse);
endmodule

// File: rtl/irq_req_datapath.sv
module irq_req_datapath
  import prio_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             extPinA,
  input  logic             extPinB,
  input  logic             timerReq,
  input  logic             regWrEn,
  input  logic             regSel,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  input  ctrl_strobe_t     strobes,
  output pend_t            pend
);
  logic [NUM_PINS-1:0] pinVec, pinLevel, pinFall;
  assign pinVec = {extPinB, extPinA};

  for (genvar g = 0; g < NUM_PINS; g++) begin : gSync
    irq_pin_sync #(.STAGES(SYNC_STAGES)) uSync (
      .clk      (clk),
      .rstN     (rstN),
      .pinIn    (pinVec[g]),
      .level    (pinLevel[g]),
      .fallPulse(pinFall[g])
    );
  end

  logic extAFlag, tmrFlag, tmrMask, extBFlag, extBMask;
  logic wrTmr, wrMisc;
  assign wrTmr  = regWrEn && !regSel;
  assign wrMisc = regWrEn &&  regSel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      extAFlag <= 1'b0;
      tmrFlag  <= 1'b0;
      tmrMask  <= 1'b0;
      extBFlag <= 1'b0;
      extBMask <= 1'b0;
    end else begin
      extAFlag <= (extAFlag & ~strobes.clrExtA) | pinFall[0];
      tmrFlag  <= (tmrFlag & (~wrTmr | regWrData[FLAG_BIT])) | timerReq;
      extBFlag <= (extBFlag & (~wrMisc | regWrData[FLAG_BIT])) | pinFall[1];
      if (wrTmr)  tmrMask  <= regWrData[MASK_BIT];
      if (wrMisc) extBMask <= regWrData[MASK_BIT];
    end
  end

  always_comb begin
    regRdData = '0;
    if (regSel) begin
      regRdData[FLAG_BIT]  = extBFlag;
      regRdData[MASK_BIT]  = extBMask;
      regRdData[LEVEL_BIT] = pinLevel[1];
    end else begin
      regRdData[FLAG_BIT]  = tmrFlag;
      regRdData[MASK_BIT]  = tmrMask;
    end
  end

  assign pend.extA   = extAFlag;
  assign pend.shared = (tmrFlag & ~tmrMask) | (extBFlag & ~extBMask);

  // R8: software writes never raise a request
  a_r8_tmr_no_write_set: assert property (@(posedge clk) disable iff (!rstN)
    (!tmrFlag && !timerReq) |=> !tmrFlag);
  a_r8_extb_no_write_set: assert property (@(posedge clk) disable iff (!rstN)
    (!extBFlag && !pinFall[1]) |=> !extBFlag);
  // R9: shared flags survive everything except a clearing write
  a_r9_extb_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (extBFlag && !(wrMisc && !regWrData[FLAG_BIT])) |=> extBFlag);
endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
  import prio_irq_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         instrDone,
  input  logic         swiReq,
  input  logic         iFlag,
  input  logic         entryAck,
  input  pend_t        pend,
  output logic         irqEntry,
  output logic         fetchGo,
  output logic [1:0]   vecSel,
  output ctrl_strobe_t strobes
);
  vec_e vecQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqEntry <= 1'b0;
      fetchGo  <= 1'b0;
      vecQ     <= VEC_SWI;
    end else begin
      irqEntry <= 1'b0;
      fetchGo  <= 1'b0;
      if (instrDone) begin
        if (swiReq) begin
          irqEntry <= 1'b1;
          vecQ     <= VEC_SWI;
        end else if (!iFlag && pend.extA) begin
          irqEntry <= 1'b1;
          vecQ     <= VEC_EXTA;
        end else if (!iFlag && pend.shared) begin
          irqEntry <= 1'b1;
          vecQ     <= VEC_SHARED;
        end else begin
          fetchGo  <= 1'b1;
        end
      end
    end
  end

  assign vecSel          = vecQ;
  assign strobes.clrExtA = entryAck && (vecQ == VEC_EXTA);

  // R3: nothing happens off the boundary
  a_r3_quiet_off_boundary: assert property (@(posedge clk) disable iff (!rstN)
    !instrDone |=> (!irqEntry && !fetchGo));
  // R4: exactly one outcome per boundary
  a_r4_one_outcome: assert property (@(posedge clk) disable iff (!rstN)
    instrDone |=> $onehot({irqEntry, fetchGo}));
  // R5: hardware blocked by the disable flag
  a_r5_iflag_blocks: assert property (@(posedge clk) disable iff (!rstN)
    (instrDone && iFlag && !swiReq) |=> !irqEntry);
  // R11: software interrupt ignores the disable flag
  a_r11_swi_taken: assert property (@(posedge clk) disable iff (!rstN)
    (instrDone && swiReq) |=> (irqEntry && vecSel == 2'b00));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             extPinA,
  input  logic             extPinB,
  input  logic             timerReq,
  input  logic             swiReq,
  input  logic             instrDone,
  input  logic             iFlag,
  input  logic             entryAck,
  input  logic             regWrEn,
  input  logic             regSel,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  output logic             irqEntry,
  output logic             fetchGo,
  output logic [1:0]       vecSel
);
  ctrl_strobe_t strobes;
  pend_t        pend;

  irq_req_datapath #(.SYNC_STAGES(SYNC_STAGES)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .extPinA  (extPinA),
    .extPinB  (extPinB),
    .timerReq (timerReq),
    .regWrEn  (regWrEn),
    .regSel   (regSel),
    .regWrData(regWrData),
    .regRdData(regRdData),
    .strobes  (strobes),
    .pend     (pend)
  );

  irq_entry_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .instrDone(instrDone),
    .swiReq   (swiReq),
    .iFlag    (iFlag),
    .entryAck (entryAck),
    .pend     (pend),
    .irqEntry (irqEntry),
    .fetchGo  (fetchGo),
    .vecSel   (vecSel),
    .strobes  (strobes)
  );
endmodule

// File: tb/tb_prio_irq_ctrl.sv
module tb_prio_irq_ctrl;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic extPinA = 1'b1, extPinB = 1'b1, timerReq = 1'b0, swiReq = 1'b0;
  logic instrDone = 1'b0, iFlag = 1'b0, entryAck = 1'b0;
  logic regWrEn = 1'b0, regSel = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic irqEntry, fetchGo;
  logic [1:0] vecSel;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  prio_irq_ctrl dut (
    .clk(clk), .rstN(rstN), .extPinA(extPinA), .extPinB(extPinB),
    .timerReq(timerReq), .swiReq(swiReq), .instrDone(instrDone),
    .iFlag(iFlag), .entryAck(entryAck), .regWrEn(regWrEn),
    .regSel(regSel), .regWrData(regWrData), .regRdData(regRdData),
    .irqEntry(irqEntry), .fetchGo(fetchGo), .vecSel(vecSel)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset();
    rstN = 1'b0; extPinA = 1'b1; extPinB = 1'b1; timerReq = 1'b0;
    swiReq = 1'b0; instrDone = 1'b0; iFlag = 1'b0; entryAck = 1'b0;
    regWrEn = 1'b0;
    step(2);
    rstN = 1'b1;
  endtask

  task automatic wr(input bit sel, input logic [7:0] d);
    regWrEn = 1'b1; regSel = sel; regWrData = d;
    step();
    regWrEn = 1'b0;
  endtask

  task automatic rd(input bit sel, output logic [7:0] v);
    regSel = sel;
    #1 v = regRdData;
  endtask

  // boundary: returns 3 for fetch, else vector code
  task automatic boundary(input bit swi, input bit iF, output int res);
    instrDone = 1'b1; swiReq = swi; iFlag = iF;
    step();
    instrDone = 1'b0; swiReq = 1'b0; iFlag = 1'b0;
    res = irqEntry ? int'(vecSel) : (fetchGo ? 3 : 4);
  endtask

  function automatic int expect_dec(bit swi, bit iF, bit a, bit sh);
    if (swi) return 0;
    if (!iF && a) return 1;
    if (!iF && sh) return 2;
    return 3;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int res;
    step();
    doReset();
    step();
    // R1 reset state
    rd(0, v); chk("R1 reg0", v, 8'h00);
    rd(1, v); chk("R1 reg1", v, 8'h01);
    chk("R1 outputs", {irqEntry, fetchGo, vecSel}, 0);

    // R2 latency on pin B
    extPinB = 1'b0;
    step(); rd(1, v); chk("R2 level after 1 edge", v, 8'h01);
    step(); rd(1, v); chk("R2 level after 2 edges", v, 8'h00);
    step(); rd(1, v); chk("R2 flag after 3 edges", v, 8'h80);
    wr(1, 8'h00); rd(1, v); chk("R8 clear pin B flag", v, 8'h00);
    extPinB = 1'b1;
    step(4); rd(1, v); chk("R2 rising edge sets nothing", v, 8'h01);

    // R8 timer register write rules
    timerReq = 1'b1; step(); timerReq = 1'b0;
    rd(0, v); chk("R8 timer flag set", v, 8'h80);
    wr(0, 8'hC0); rd(0, v); chk("R8 write 1 keeps flag, sets mask", v, 8'hC0);
    wr(0, 8'h40); rd(0, v); chk("R8 write 0 clears flag", v, 8'h40);
    wr(0, 8'h80); rd(0, v); chk("R8 write 1 cannot set flag", v, 8'h00);
    timerReq = 1'b1; regWrEn = 1'b1; regSel = 1'b0; regWrData = 8'h00;
    step(); timerReq = 1'b0; regWrEn = 1'b0;
    rd(0, v); chk("R8 arrival beats clear", v, 8'h80);
    wr(0, 8'h00);

    // R10 level visible while masked; R6 masked latch
    wr(1, 8'h40);
    extPinB = 1'b0;
    step(2); rd(1, v); chk("R10 level with mask set", v, 8'h40);
    step(); rd(1, v); chk("R6 masked request latched", v, 8'hC0);
    extPinB = 1'b1;
    step(3);
    boundary(0, 0, res); chk("R6 masked not taken", res, 3);
    wr(1, 8'h80);
    boundary(0, 0, res); chk("R6 taken after unmask", res, 2);
    wr(1, 8'h00);

    // R3 hold pin A pending without a boundary
    extPinA = 1'b0; step(4); extPinA = 1'b1;
    for (int k = 0; k < 5; k++) begin
      step();
      chk("R3 no pulse off boundary", {irqEntry, fetchGo}, 0);
    end
    boundary(0, 0, res); chk("R3 pending kept until boundary", res, 1);
    entryAck = 1'b1; step(); entryAck = 1'b0;

    // sweep: R4 R5 R7 R9 R11
    for (int c = 0; c < 128; c++) begin
      bit a, t, tm, b, bm, iF, swi;
      int e1, e2;
      {a, t, tm, b, bm, iF, swi} = 7'(c);
      doReset();
      step();
      wr(0, {1'b1, tm, 6'b0});
      wr(1, {1'b1, bm, 6'b0});
      extPinA = ~a; extPinB = ~b; timerReq = t;
      step(); timerReq = 1'b0;
      step(3);
      extPinA = 1'b1; extPinB = 1'b1;
      step(3);
      e1 = expect_dec(swi, iF, a, (t & ~tm) | (b & ~bm));
      boundary(swi, iF, res);
      chk("R4 R5 R7 R11 first boundary", res, e1);
      if (e1 != 3) begin
        entryAck = 1'b1; step(); entryAck = 1'b0;
      end
      e2 = expect_dec(0, 0, a && (e1 != 1), (t & ~tm) | (b & ~bm));
      boundary(0, 0, res);
      chk("R9 second boundary after ack", res, e2);
      rd(0, v); chk("R9 timer flag sticky", int'(v[7]), int'(t));
      rd(1, v); chk("R9 pin B flag sticky", int'(v[7]), int'(b));
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule